// File: doc/BRIEF.md
# Dual-Master Cache-Line Port Arbiter

This block lets two cache-line masters, channel A and channel B, share one memory-controller port. Each channel presents whole transactions (a read of one line, or a write) through its own request, write-data and read-data valid/ready paths. The arbiter picks one channel, frames the transaction as a single downstream command that carries the start word address, the beat count, the direction and a wrap flag, and keeps that channel as owner until the last data beat has moved. Read beats coming back from memory are steered only to the owning channel, using a registered owner tag.

Each channel is configured on its own: line size of 1, 4, 8 or 16 words; write mode 1 (single-word writes) or 2 (whole-line writes); and an optional requested-word-first read order. With that option a read command carries the requested word address and sets the wrap flag, so the memory returns the requested word first and then the rest of the line, wrapping within the aligned line. Arbitration favours channel B when both channels start from a quiet arbiter, and alternates between them when both keep requesting.

Top module: `twin_line_arb`

## Requirements
- R1: When the arbiter has been idle for a cycle with neither channel requesting, and both channels then request in the same cycle, channel B is granted (b_req_ready high, a_req_ready low).
- R2: When both channels request back to back, grants alternate between B and A; after each completed transaction the preferred channel becomes the one not just served.
- R3: While idle, a single requesting channel is granted in that cycle whichever channel is currently preferred.
- R4: At most one request is accepted at a time, and no request is accepted from acceptance until the final data beat of that transaction.
- R5: A read command has m_cmd_len equal to the channel's line size minus one (field holds beats minus one), the channel receives exactly that many beats, and its rd_last is high only on the final beat.
- R6: On a channel in write mode 1, a write command carries the requested word address with m_cmd_len 0, and exactly one beat is taken from that channel's write path with m_wr_last high.
- R7: On a channel in write mode 2, a write command carries the line-aligned address (low log2(line) bits zero), m_cmd_len equal to line minus one, and the line's beats are forwarded in order with m_wr_last on the final one.
- R8: On a channel with requested-word-first enabled and line above 1, a read command carries the requested address with m_cmd_wrap 1, and the channel sees the requested word first, then the following words wrapping within the aligned line; otherwise the command carries the aligned address with m_cmd_wrap 0 and words arrive in ascending order.
- R9: Read beats are presented only on the owning channel; the other channel's rd_valid stays low.
- R10: Once m_cmd_valid is high it stays high, with address, length and direction unchanged, until m_cmd_ready accepts it.
- R11: During and right after reset, a_req_ready, b_req_ready, m_cmd_valid, m_wr_valid, a_rd_valid and b_rd_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req_valid | input | 1 | Channel A transaction request |
| a_req_ready | output | 1 | Channel A request accepted |
| a_req_addr | input | AW | Channel A word address |
| a_req_write | input | 1 | Channel A: 1 write, 0 read |
| a_wr_valid | input | 1 | Channel A write beat valid |
| a_wr_ready | output | 1 | Channel A write beat taken |
| a_wr_data | input | DW | Channel A write beat |
| a_rd_valid | output | 1 | Channel A read beat valid |
| a_rd_ready | input | 1 | Channel A can take a read beat |
| a_rd_data | output | DW | Channel A read beat |
| a_rd_last | output | 1 | Channel A final read beat |
| b_req_valid | input | 1 | Channel B transaction request |
| b_req_ready | output | 1 | Channel B request accepted |
| b_req_addr | input | AW | Channel B word address |
| b_req_write | input | 1 | Channel B: 1 write, 0 read |
| b_wr_valid | input | 1 | Channel B write beat valid |
| b_wr_ready | output | 1 | Channel B write beat taken |
| b_wr_data | input | DW | Channel B write beat |
| b_rd_valid | output | 1 | Channel B read beat valid |
| b_rd_ready | input | 1 | Channel B can take a read beat |
| b_rd_data | output | DW | Channel B read beat |
| b_rd_last | output | 1 | Channel B final read beat |
| m_cmd_valid | output | 1 | Downstream command valid |
| m_cmd_ready | input | 1 | Downstream command accepted |
| m_cmd_addr | output | AW | Start word address |
| m_cmd_len | output | 4 | Beats minus one |
| m_cmd_write | output | 1 | 1 write, 0 read |
| m_cmd_wrap | output | 1 | Read wraps within the aligned line |
| m_wr_valid | output | 1 | Downstream write beat valid |
| m_wr_ready | input | 1 | Downstream write beat taken |
| m_wr_data | output | DW | Downstream write beat |
| m_wr_last | output | 1 | Final write beat |
| m_rd_valid | input | 1 | Downstream read beat valid |
| m_rd_ready | output | 1 | Downstream read beat taken |
| m_rd_data | input | DW | Downstream read beat |

## Verification
The hardest situation to reach from the ports is a grant decision in the very cycle after a transaction completes, with the other channel already waiting and the just-served channel re-raising its request at once; only then does the alternating preference decide, rather than the quiet-start bias toward B. The bench drives two concurrent master processes that re-request on the first clock after their last read beat, and separately runs a lone channel B twice back to back (preference pointing at A) and a B transaction followed by an idle gap before a simultaneous start, so the preference reset on a quiet cycle is told apart from the pointer update.

// File: rtl/tla_pkg.sv
`timescale 1ns/1ps
package tla_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } tla_state_e;

  localparam int unsigned NCH  = 2;
  localparam int unsigned LENW = 4;
endpackage

// File: rtl/tla_frame.sv
`timescale 1ns/1ps
module tla_frame
  import tla_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned LINE  = 4,
  parameter int unsigned WMODE = 2,
  parameter bit          TWF   = 1'b0
) (
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  output logic [AW-1:0]   cmd_addr,
  output logic [LENW-1:0] cmd_len_m1,
  output logic            cmd_wrap
);
  localparam int unsigned    LW      = (LINE > 1) ? $clog2(LINE) : 0;
  localparam logic [LENW-1:0] LINE_M1 = LENW'(LINE - 1);

  logic [AW-1:0] line_base;

  generate
    if (LW == 0) begin : g_word_line
      assign line_base = req_addr;
    end else begin : g_multi_line
      assign line_base = {req_addr[AW-1:LW], {LW{1'b0}}};
    end
  endgenerate

  always_comb begin
    cmd_addr   = line_base;
    cmd_len_m1 = LINE_M1;
    cmd_wrap   = 1'b0;
    if (req_write) begin
      if (WMODE == 1) begin
        cmd_addr   = req_addr;
        cmd_len_m1 = '0;
      end
    end else if (TWF && (LINE > 1)) begin
      cmd_addr = req_addr;
      cmd_wrap = 1'b1;
    end
  end
endmodule

// File: rtl/tla_rr.sv
`timescale 1ns/1ps
module tla_rr (
  input  logic       clk,
  input  logic       rst,
  input  logic       arb_en,
  input  logic [1:0] req,
  input  logic       done,
  input  logic       done_ch,
  output logic [1:0] grant,
  output logic       pref_q
);
  always_comb begin
    grant = 2'b00;
    if (arb_en) begin
      unique case (req)
        2'b01:   grant = 2'b01;
        2'b10:   grant = 2'b10;
        2'b11:   grant = pref_q ? 2'b10 : 2'b01;
        default: grant = 2'b00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pref_q <= 1'b1;
    end else if (done) begin
      pref_q <= ~done_ch;
    end else if (arb_en && (req == 2'b00)) begin
      pref_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tla_route.sv
`timescale 1ns/1ps
module tla_route
  import tla_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            load_owner,
  input  logic            load_write,
  input  logic [LENW-1:0] load_len_m1,
  input  logic            active,
  input  logic            a_wr_valid,
  input  logic [DW-1:0]   a_wr_data,
  output logic            a_wr_ready,
  input  logic            b_wr_valid,
  input  logic [DW-1:0]   b_wr_data,
  output logic            b_wr_ready,
  output logic            m_wr_valid,
  input  logic            m_wr_ready,
  output logic [DW-1:0]   m_wr_data,
  output logic            m_wr_last,
  input  logic            m_rd_valid,
  input  logic [DW-1:0]   m_rd_data,
  output logic            m_rd_ready,
  output logic            a_rd_valid,
  output logic [DW-1:0]   a_rd_data,
  output logic            a_rd_last,
  input  logic            a_rd_ready,
  output logic            b_rd_valid,
  output logic [DW-1:0]   b_rd_data,
  output logic            b_rd_last,
  input  logic            b_rd_ready,
  output logic            done,
  output logic            owner
);
  logic            owner_q;
  logic            write_q;
  logic [LENW-1:0] len_q;
  logic [LENW-1:0] cnt_q;
  logic            act_wr, act_rd, last, beat;

  assign owner  = owner_q;
  assign act_wr = active & write_q;
  assign act_rd = active & ~write_q;
  assign last   = (cnt_q == len_q);

  assign m_wr_valid = act_wr & (owner_q ? b_wr_valid : a_wr_valid);
  assign m_wr_data  = owner_q ? b_wr_data : a_wr_data;
  assign m_wr_last  = act_wr & last;
  assign a_wr_ready = act_wr & ~owner_q & m_wr_ready;
  assign b_wr_ready = act_wr &  owner_q & m_wr_ready;

  assign m_rd_ready = act_rd & (owner_q ? b_rd_ready : a_rd_ready);
  assign a_rd_valid = act_rd & ~owner_q & m_rd_valid;
  assign b_rd_valid = act_rd &  owner_q & m_rd_valid;
  assign a_rd_data  = m_rd_data;
  assign b_rd_data  = m_rd_data;
  assign a_rd_last  = act_rd & ~owner_q & last;
  assign b_rd_last  = act_rd &  owner_q & last;

  assign beat = (m_wr_valid & m_wr_ready) | (act_rd & m_rd_valid & m_rd_ready);
  assign done = beat & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= 1'b0;
      write_q <= 1'b0;
      len_q   <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      owner_q <= load_owner;
      write_q <= load_write;
      len_q   <= load_len_m1;
      cnt_q   <= '0;
    end else if (beat) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/twin_line_arb.sv
`timescale 1ns/1ps
module twin_line_arb
  import tla_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 32,
  parameter int unsigned A_LINE  = 4,
  parameter int unsigned B_LINE  = 8,
  parameter int unsigned A_WMODE = 2,
  parameter int unsigned B_WMODE = 1,
  parameter bit          A_TWF   = 1'b1,
  parameter bit          B_TWF   = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_req_valid,
  output logic          a_req_ready,
  input  logic [AW-1:0] a_req_addr,
  input  logic          a_req_write,
  input  logic          a_wr_valid,
  output logic          a_wr_ready,
  input  logic [DW-1:0] a_wr_data,
  output logic          a_rd_valid,
  input  logic          a_rd_ready,
  output logic [DW-1:0] a_rd_data,
  output logic          a_rd_last,
  input  logic          b_req_valid,
  output logic          b_req_ready,
  input  logic [AW-1:0] b_req_addr,
  input  logic          b_req_write,
  input  logic          b_wr_valid,
  output logic          b_wr_ready,
  input  logic [DW-1:0] b_wr_data,
  output logic          b_rd_valid,
  input  logic          b_rd_ready,
  output logic [DW-1:0] b_rd_data,
  output logic          b_rd_last,
  output logic          m_cmd_valid,
  input  logic          m_cmd_ready,
  output logic [AW-1:0] m_cmd_addr,
  output logic [3:0]    m_cmd_len,
  output logic          m_cmd_write,
  output logic          m_cmd_wrap,
  output logic          m_wr_valid,
  input  logic          m_wr_ready,
  output logic [DW-1:0] m_wr_data,
  output logic          m_wr_last,
  input  logic          m_rd_valid,
  output logic          m_rd_ready,
  input  logic [DW-1:0] m_rd_data
);
  tla_state_e      st;
  logic [NCH-1:0]  req_v;
  logic [NCH-1:0]  req_w;
  logic [AW-1:0]   req_a   [NCH];
  logic [AW-1:0]   f_addr  [NCH];
  logic [LENW-1:0] f_len   [NCH];
  logic [NCH-1:0]  f_wrap;
  logic [NCH-1:0]  grant;
  logic            win;
  logic            take;
  logic            done;
  logic            owner;
  logic            pref_unused;

  assign req_v = {b_req_valid, a_req_valid};
  assign req_w = {b_req_write, a_req_write};
  assign req_a[0] = a_req_addr;
  assign req_a[1] = b_req_addr;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      tla_frame #(
        .AW   (AW),
        .LINE ((g == 0) ? A_LINE  : B_LINE),
        .WMODE((g == 0) ? A_WMODE : B_WMODE),
        .TWF  ((g == 0) ? A_TWF   : B_TWF)
      ) u_frame (
        .req_addr  (req_a[g]),
        .req_write (req_w[g]),
        .cmd_addr  (f_addr[g]),
        .cmd_len_m1(f_len[g]),
        .cmd_wrap  (f_wrap[g])
      );
    end
  endgenerate

  tla_rr u_rr (
    .clk    (clk),
    .rst    (rst),
    .arb_en (st == ST_IDLE),
    .req    (req_v),
    .done   (done),
    .done_ch(owner),
    .grant  (grant),
    .pref_q (pref_unused)
  );

  assign take        = |grant;
  assign win         = grant[1];
  assign a_req_ready = grant[0];
  assign b_req_ready = grant[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      m_cmd_valid <= 1'b0;
      m_cmd_addr  <= '0;
      m_cmd_len   <= '0;
      m_cmd_write <= 1'b0;
      m_cmd_wrap  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (take) begin
          st          <= ST_CMD;
          m_cmd_valid <= 1'b1;
          m_cmd_addr  <= f_addr[win];
          m_cmd_len   <= f_len[win];
          m_cmd_write <= req_w[win];
          m_cmd_wrap  <= f_wrap[win];
        end
        ST_CMD: if (m_cmd_ready) begin
          st          <= ST_DATA;
          m_cmd_valid <= 1'b0;
        end
        ST_DATA: if (done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  tla_route #(.DW(DW)) u_route (
    .clk        (clk),
    .rst        (rst),
    .load       (take),
    .load_owner (win),
    .load_write (req_w[win]),
    .load_len_m1(f_len[win]),
    .active     (st == ST_DATA),
    .a_wr_valid (a_wr_valid),
    .a_wr_data  (a_wr_data),
    .a_wr_ready (a_wr_ready),
    .b_wr_valid (b_wr_valid),
    .b_wr_data  (b_wr_data),
    .b_wr_ready (b_wr_ready),
    .m_wr_valid (m_wr_valid),
    .m_wr_ready (m_wr_ready),
    .m_wr_data  (m_wr_data),
    .m_wr_last  (m_wr_last),
    .m_rd_valid (m_rd_valid),
    .m_rd_data  (m_rd_data),
    .m_rd_ready (m_rd_ready),
    .a_rd_valid (a_rd_valid),
    .a_rd_data  (a_rd_data),
    .a_rd_last  (a_rd_last),
    .a_rd_ready (a_rd_ready),
    .b_rd_valid (b_rd_valid),
    .b_rd_data  (b_rd_data),
    .b_rd_last  (b_rd_last),
    .b_rd_ready (b_rd_ready),
    .done       (done),
    .owner      (owner)
  );
endmodule

// File: rtl/tla_checker.sv
`timescale 1ns/1ps
module tla_checker #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          a_req_valid,
  input logic          b_req_valid,
  input logic          a_req_ready,
  input logic          b_req_ready,
  input logic          a_rd_valid,
  input logic          b_rd_valid,
  input logic          m_cmd_valid,
  input logic          m_cmd_ready,
  input logic [AW-1:0] m_cmd_addr,
  input logic [3:0]    m_cmd_len,
  input logic          m_cmd_write,
  input logic          busy,
  input logic          pref_b
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    !(a_req_ready && b_req_ready)); // R4

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!a_req_ready && !b_req_ready)); // R4

  AST_QUIET_PREF_B: assert property (@(posedge clk) disable iff (rst)
    (!busy && !a_req_valid && !b_req_valid) |=> pref_b); // R1

  AST_TIE_FOLLOWS_PREF: assert property (@(posedge clk) disable iff (rst)
    (!busy && a_req_valid && b_req_valid) |-> ((b_req_ready == pref_b) && (a_req_ready == !pref_b))); // R2

  AST_SOLO_WINS: assert property (@(posedge clk) disable iff (rst)
    (!busy && (a_req_valid ^ b_req_valid)) |-> ((a_req_ready == a_req_valid) && (b_req_ready == b_req_valid))); // R3

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (m_cmd_valid && !m_cmd_ready) |=> (m_cmd_valid && $stable(m_cmd_addr) && $stable(m_cmd_len) && $stable(m_cmd_write))); // R10

  AST_RD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(a_rd_valid && b_rd_valid)); // R9
endmodule

bind twin_line_arb tla_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .a_req_valid(a_req_valid),
  .b_req_valid(b_req_valid),
  .a_req_ready(a_req_ready),
  .b_req_ready(b_req_ready),
  .a_rd_valid (a_rd_valid),
  .b_rd_valid (b_rd_valid),
  .m_cmd_valid(m_cmd_valid),
  .m_cmd_ready(m_cmd_ready),
  .m_cmd_addr (m_cmd_addr),
  .m_cmd_len  (m_cmd_len),
  .m_cmd_write(m_cmd_write),
  .busy       (st != ST_IDLE),
  .pref_b     (u_rr.pref_q)
);

// File: tb/twin_line_arb_bench.sv
`timescale 1ns/1ps
module twin_line_arb_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int A_LINE = 4;
  localparam int B_LINE = 8;
  localparam int A_WMODE = 2;
  localparam int B_WMODE = 1;
  localparam bit A_TWF = 1'b1;
  localparam bit B_TWF = 1'b0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic a_req_valid = 0, a_req_ready, a_req_write = 0;
  logic [AW-1:0] a_req_addr = '0;
  logic a_wr_valid = 0, a_wr_ready;
  logic [DW-1:0] a_wr_data = '0;
  logic a_rd_valid, a_rd_last;
  logic [DW-1:0] a_rd_data;
  logic b_req_valid = 0, b_req_ready, b_req_write = 0;
  logic [AW-1:0] b_req_addr = '0;
  logic b_wr_valid = 0, b_wr_ready;
  logic [DW-1:0] b_wr_data = '0;
  logic b_rd_valid, b_rd_last;
  logic [DW-1:0] b_rd_data;
  logic m_cmd_valid, m_cmd_ready = 0, m_cmd_write, m_cmd_wrap;
  logic [AW-1:0] m_cmd_addr;
  logic [3:0] m_cmd_len;
  logic m_wr_valid, m_wr_last, m_rd_ready;
  logic [DW-1:0] m_wr_data;
  logic m_rd_valid = 0;
  logic [DW-1:0] m_rd_data = '0;

  twin_line_arb #(
    .AW(AW), .DW(DW), .A_LINE(A_LINE), .B_LINE(B_LINE),
    .A_WMODE(A_WMODE), .B_WMODE(B_WMODE), .A_TWF(A_TWF), .B_TWF(B_TWF)
  ) u_twin_line_arb (
    .clk(clk), .rst(rst),
    .a_req_valid(a_req_valid), .a_req_ready(a_req_ready), .a_req_addr(a_req_addr), .a_req_write(a_req_write),
    .a_wr_valid(a_wr_valid), .a_wr_ready(a_wr_ready), .a_wr_data(a_wr_data),
    .a_rd_valid(a_rd_valid), .a_rd_ready(1'b1), .a_rd_data(a_rd_data), .a_rd_last(a_rd_last),
    .b_req_valid(b_req_valid), .b_req_ready(b_req_ready), .b_req_addr(b_req_addr), .b_req_write(b_req_write),
    .b_wr_valid(b_wr_valid), .b_wr_ready(b_wr_ready), .b_wr_data(b_wr_data),
    .b_rd_valid(b_rd_valid), .b_rd_ready(1'b1), .b_rd_data(b_rd_data), .b_rd_last(b_rd_last),
    .m_cmd_valid(m_cmd_valid), .m_cmd_ready(m_cmd_ready), .m_cmd_addr(m_cmd_addr), .m_cmd_len(m_cmd_len),
    .m_cmd_write(m_cmd_write), .m_cmd_wrap(m_cmd_wrap),
    .m_wr_valid(m_wr_valid), .m_wr_ready(1'b1), .m_wr_data(m_wr_data), .m_wr_last(m_wr_last),
    .m_rd_valid(m_rd_valid), .m_rd_ready(m_rd_ready), .m_rd_data(m_rd_data)
  );

  int n_chk = 0;
  int n_err = 0;
  int ord[64];
  int n_ord = 0;
  logic [AW-1:0] lg_addr;
  int lg_len;
  bit lg_write, lg_wrap;

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rdat(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction
  function automatic logic [DW-1:0] wdat(input logic [AW-1:0] a);
    return {a, a ^ 16'h0F0F};
  endfunction

  // Memory model: wrap keeps the beat inside the len-aligned block.
  function automatic logic [AW-1:0] mem_beat(input logic [AW-1:0] base, input int i, input int len, input bit wrap);
    int b = int'(base);
    if (wrap) return AW'((b & ~(len - 1)) | ((b + i) & (len - 1)));
    return AW'(b + i);
  endfunction

  initial begin : memory
    int mcyc = 0;
    bit busy = 0, wr = 0, wrap = 0, hold = 0;
    int len = 0, cnt = 0;
    logic [AW-1:0] base = '0, hold_addr = '0;
    forever begin
      @(negedge clk);
      mcyc++;
      m_cmd_ready = (mcyc % 3 == 0);
      if (busy && !wr && cnt < len) begin
        m_rd_valid = 1'b1;
        m_rd_data  = rdat(mem_beat(base, cnt, len, wrap));
      end else begin
        m_rd_valid = 1'b0;
      end
      #1;
      if (rst) continue;
      if (hold) chk(m_cmd_valid && m_cmd_addr == hold_addr, "R10", "command held until ready",
                    longint'(m_cmd_addr), longint'(hold_addr));
      hold = 0;
      if (!busy && m_cmd_valid) begin
        if (m_cmd_ready) begin
          busy = 1; cnt = 0; base = m_cmd_addr; len = int'(m_cmd_len) + 1;
          wr = m_cmd_write; wrap = m_cmd_wrap;
          lg_addr = m_cmd_addr; lg_len = int'(m_cmd_len); lg_write = m_cmd_write; lg_wrap = m_cmd_wrap;
        end else begin
          hold = 1; hold_addr = m_cmd_addr;
        end
      end else if (busy && !wr) begin
        if (m_rd_valid && m_rd_ready) begin
          cnt++;
          if (cnt == len) busy = 0;
        end
      end else if (busy && wr) begin
        if (m_wr_valid) begin
          chk(m_wr_data == wdat(base + AW'(cnt)), "R7", "write beat data in order",
              longint'(m_wr_data), longint'(wdat(base + AW'(cnt))));
          chk(m_wr_last == (cnt == len - 1), "R6", "write last flag", longint'(m_wr_last), longint'(cnt == len - 1));
          cnt++;
          if (cnt == len) busy = 0;
        end
      end
    end
  end

  initial begin : grant_hold_monitor
    bit outst = 0;
    forever begin
      @(negedge clk);
      #1;
      if (rst) continue;
      if ((a_req_valid && a_req_ready) || (b_req_valid && b_req_ready)) begin
        chk(!outst, "R4", "no accept while transaction in flight", longint'(outst), 0);
        outst = 1;
      end
      if ((a_rd_valid && a_rd_last) || (b_rd_valid && b_rd_last) || (m_wr_valid && m_wr_last)) outst = 0;
    end
  end

  task automatic run_txn(input int ch, input logic [AW-1:0] addr, input bit wr);
    int L = ch ? B_LINE : A_LINE;
    int wm = ch ? B_WMODE : A_WMODE;
    bit twf = ch ? B_TWF : A_TWF;
    logic [AW-1:0] al = addr & ~AW'(L - 1);
    logic [AW-1:0] e_addr;
    int e_len, nb, k;
    bit e_wrap, acc;
    string rtag;
    if (wr) begin
      e_addr = (wm == 1) ? addr : al; e_len = (wm == 1) ? 0 : L - 1; e_wrap = 0;
      rtag = (wm == 1) ? "R6" : "R7";
    end else begin
      e_addr = (twf && L > 1) ? addr : al; e_len = L - 1; e_wrap = twf && L > 1;
      rtag = "R8";
    end
    @(negedge clk);
    if (ch == 1) begin b_req_valid = 1; b_req_addr = addr; b_req_write = wr; end
    else begin a_req_valid = 1; a_req_addr = addr; a_req_write = wr; end
    do begin
      #1;
      acc = ch ? b_req_ready : a_req_ready;
      if (acc) begin ord[n_ord] = ch; n_ord++; end
      @(negedge clk);
    end while (!acc);
    if (ch == 1) b_req_valid = 0; else a_req_valid = 0;
    if (wr) begin
      nb = (wm == 1) ? 1 : L;
      for (int j = 0; j < nb; j++) begin
        logic [AW-1:0] wa = (wm == 1) ? addr : al + AW'(j);
        if (ch == 1) begin b_wr_valid = 1; b_wr_data = wdat(wa); end
        else begin a_wr_valid = 1; a_wr_data = wdat(wa); end
        do begin
          #1;
          acc = ch ? b_wr_ready : a_wr_ready;
          if (acc && j == nb - 1) begin
            chk(lg_addr == e_addr, rtag, "write command address", longint'(lg_addr), longint'(e_addr));
            chk(lg_len == e_len && lg_write, rtag, "write command length", longint'(lg_len), longint'(e_len));
          end
          @(negedge clk);
        end while (!acc);
      end
      if (ch == 1) b_wr_valid = 0; else a_wr_valid = 0;
    end else begin
      k = 0;
      forever begin
        #1;
        if (ch ? b_rd_valid : a_rd_valid) begin
          logic [AW-1:0] wa = e_wrap ? (al | ((addr + AW'(k)) & AW'(L - 1))) : al + AW'(k);
          logic [DW-1:0] got = ch ? b_rd_data : a_rd_data;
          bit lst = ch ? b_rd_last : a_rd_last;
          bit oth = ch ? a_rd_valid : b_rd_valid;
          chk(got == rdat(wa), "R8", "read word order", longint'(got), longint'(rdat(wa)));
          chk(lst == (k == L - 1), "R5", "read last flag", longint'(lst), longint'(k == L - 1));
          chk(!oth, "R9", "other channel read valid low", longint'(oth), 0);
          k++;
          if (k == L) begin
            chk(lg_len == e_len && !lg_write, "R5", "read command length", longint'(lg_len), longint'(e_len));
            chk(lg_addr == e_addr, "R8", "read command address", longint'(lg_addr), longint'(e_addr));
            chk(lg_wrap == e_wrap, "R8", "read wrap flag", longint'(lg_wrap), longint'(e_wrap));
            break;
          end
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin : main
    repeat (5) @(posedge clk);
    @(negedge clk);
    #1;
    // R11: reset state
    chk(!a_req_ready && !b_req_ready, "R11", "no grant in reset", longint'({a_req_ready, b_req_ready}), 0);
    chk(!m_cmd_valid && !m_wr_valid, "R11", "no downstream valid in reset", longint'({m_cmd_valid, m_wr_valid}), 0);
    rst = 0;
    @(negedge clk);
    #1;
    chk(!m_cmd_valid && !a_rd_valid && !b_rd_valid, "R11", "quiet after reset",
        longint'({m_cmd_valid, a_rd_valid, b_rd_valid}), 0);

    for (int o = 0; o < A_LINE; o++) run_txn(0, 16'h0100 + 16'(o), 0);
    for (int o = 0; o < B_LINE; o++) run_txn(1, 16'h0208 + 16'(o), 0);
    for (int o = 0; o < A_LINE; o++) run_txn(0, 16'h0300 + 16'(o), 1);
    run_txn(1, 16'h0400, 1);
    run_txn(1, 16'h0403, 1);
    run_txn(1, 16'h0407, 1);

    // R3: lone B requests twice back to back while preference points at A
    repeat (3) @(negedge clk);
    n_ord = 0;
    run_txn(1, 16'h0500, 0);
    run_txn(1, 16'h0510, 0);
    chk(n_ord == 2 && ord[0] == 1 && ord[1] == 1, "R3", "lone requester wins", longint'(ord[1]), 1);

    // R1: B served alone, quiet gap, then simultaneous start -> B first
    repeat (3) @(negedge clk);
    run_txn(1, 16'h0600, 0);
    repeat (3) @(negedge clk);
    n_ord = 0;
    fork
      run_txn(0, 16'h0700, 0);
      run_txn(1, 16'h0710, 0);
    join
    chk(ord[0] == 1, "R1", "tie from idle goes to B", longint'(ord[0]), 1);
    chk(ord[1] == 0, "R1", "A follows after tie", longint'(ord[1]), 0);

    // R2: sustained contention alternates
    repeat (3) @(negedge clk);
    n_ord = 0;
    fork
      for (int i = 0; i < 6; i++) run_txn(0, 16'h0800 + 16'(i * 5), 0);
      for (int i = 0; i < 6; i++) run_txn(1, 16'h0900 + 16'(i * 9), 0);
    join
    chk(n_ord == 12, "R2", "grant count", longint'(n_ord), 12);
    for (int i = 0; i < 12; i++)
      chk(ord[i] == ((i % 2 == 0) ? 1 : 0), "R2", "alternating grant", longint'(ord[i]), longint'((i % 2 == 0) ? 1 : 0));

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule